// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block services a 4x4 switch matrix whose four row lines are pulled high off-chip and whose four column lines it drives. While idle it holds every column low. Any pressed switch then pulls its row low. The AND of the active-low rows is brought out as a single press request. Internally the first low row is turned into a one-cycle detect event.

After the detect event the block waits out contact bounce. It then walks the columns one at a time, driving only that column low and waiting a settle delay before it samples the rows. The first column that shows a low row gives the key position, which is reported as a 4-bit index with a one-cycle valid strobe. The block then holds all columns low and re-arms only after the rows have read high for a full bounce interval.

Rows pass through a synchronizer before any decision is made. The settle delay must cover that latency (at least 2 cycles with the default 2 stages).

Top module: `keypad_scanner`

## Requirements
- R1: After reset, col_o is 4'b0000 (all columns low), key_valid_o is 0 and detect_o is 0; while idle, all columns stay low.
- R2: press_req_o is 0 whenever at least one row_i bit is 0 and 1 when all four rows are 1; row_i bit r is row r.
- R3: The first low row seen while idle raises detect_o for exactly one cycle, and no further detect_o occurs until the block has re-armed.
- R4: After detect_o, all columns stay low for at least BOUNCE_CYC cycles, counted from the detect_o cycle, before any column is released high.
- R5: A scan drives exactly one column low at a time (col_o bit c is column c, 0 = driven low), in order column 0, 1, 2, 3, and holds each pattern for at least SETTLE_CYC cycles.
- R6: The reported key_idx_o equals row*4 + column, where the row is the low row and the column is the one driven low when the rows were sampled.
- R7: key_valid_o is a single-cycle pulse, and one press gives exactly one pulse even when the contact bounces on press and on release.
- R8: If a scan of all four columns finds no low row, no key is reported and the block returns to idle with all columns low.
- R9: After a report, all columns stay low, and the block re-arms only once the rows have read all high for a full BOUNCE_CYC interval; a row going low earlier restarts that interval and yields no new event.
- R10: When several rows are low in the same scanned column, the lowest-numbered row is reported; when keys sit in different columns, the lowest-numbered column found in the scan wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_i | input | 4 | Row lines, pulled high, 0 = connected to a low column |
| col_o | output | 4 | Column drive, 0 = driven low |
| press_req_o | output | 1 | AND of the rows, falls when any key closes |
| detect_o | output | 1 | One-cycle key-detect event |
| key_idx_o | output | 4 | Index of the last reported key, row*4 + column |
| key_valid_o | output | 1 | One-cycle strobe qualifying key_idx_o |

## Verification
The bench bounces the contacts on both press and release. A design that skipped the bounce wait, or re-armed too early, would show extra detect or valid pulses. A short glitch that is gone before the scan must run through all four columns in order and report nothing; a design without the empty-scan exit would hang or invent a key. Presses that arrive during the release interval must be swallowed, which catches a design that re-arms on the first high sample. Two keys in one column, and two keys in different columns, expose a wrong row priority or a wrong column order through the reported index.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOUNCE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_HOLD
  } kp_state_e;
endpackage

// File: rtl/kp_row_sync.sv
module kp_row_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= '1;
    else         q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[s] <= '1;
      else         q[s] <= q[s-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/kp_down_timer.sv
module kp_down_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt <= '0;
    else if (load_i)    cnt <= val_i;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/kp_row_pick.sv
module kp_row_pick #(
  parameter int ROWS = 4,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0] rows_i,
  output logic            hit_o,
  output logic [RW-1:0]   idx_o
);
  // lowest-numbered low row wins
  always_comb begin
    idx_o = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (!rows_i[r]) idx_o = RW'(r);
    end
  end

  assign hit_o = ~&rows_i;
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kp_pkg::*;
#(
  parameter int ROWS        = 4,
  parameter int COLS        = 4,
  parameter int BOUNCE_CYC  = 100000,
  parameter int SETTLE_CYC  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int KW = $clog2(ROWS * COLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ROWS-1:0] row_i,
  output logic [COLS-1:0] col_o,
  output logic            press_req_o,
  output logic            detect_o,
  output logic [KW-1:0]   key_idx_o,
  output logic            key_valid_o
);
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int TMAX = (BOUNCE_CYC > SETTLE_CYC) ? BOUNCE_CYC : SETTLE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] BOUNCE_LD = TW'(BOUNCE_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] COL_LAST  = CW'(COLS - 1);

  kp_state_e       state_q, state_d;
  logic [CW-1:0]   col_q, col_d;
  logic [ROWS-1:0] rows_s;
  logic            any_low;
  logic [RW-1:0]   hit_row;
  logic            t_load, t_done;
  logic [TW-1:0]   t_val;
  logic            report;
  logic            detect_d;
  logic [KW-1:0]   idx_q;
  logic            valid_q, detect_q;

  assign press_req_o = &row_i;

  kp_row_sync #(.W(ROWS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (row_i),
    .q_o    (rows_s)
  );

  kp_row_pick #(.ROWS(ROWS)) u_pick (
    .rows_i (rows_s),
    .hit_o  (any_low),
    .idx_o  (hit_row)
  );

  kp_down_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .done_o (t_done)
  );

  always_comb begin
    state_d  = state_q;
    col_d    = col_q;
    t_load   = 1'b0;
    t_val    = SETTLE_LD;
    report   = 1'b0;
    detect_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_low) begin
          state_d  = ST_BOUNCE;
          t_load   = 1'b1;
          t_val    = BOUNCE_LD;
          detect_d = 1'b1;
        end
      end
      ST_BOUNCE: begin
        if (t_done) begin
          state_d = ST_SETTLE;
          col_d   = '0;
          t_load  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (t_done) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (any_low) begin
          state_d = ST_HOLD;
          report  = 1'b1;
          t_load  = 1'b1;
          t_val   = BOUNCE_LD;
        end else if (col_q == COL_LAST) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_SETTLE;
          col_d   = col_q + 1'b1;
          t_load  = 1'b1;
        end
      end
      ST_HOLD: begin
        // any low row restarts the quiet interval
        if (any_low) begin
          t_load = 1'b1;
          t_val  = BOUNCE_LD;
        end else if (t_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      col_q    <= '0;
      idx_q    <= '0;
      valid_q  <= 1'b0;
      detect_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      col_q    <= col_d;
      valid_q  <= report;
      detect_q <= detect_d;
      if (report) idx_q <= KW'(hit_row) * KW'(COLS) + KW'(col_q);
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_o[c] = ((state_q == ST_SETTLE) || (state_q == ST_SAMPLE))
                      ? (col_q != CW'(c)) : 1'b0;
  end

  assign detect_o    = detect_q;
  assign key_idx_o   = idx_q;
  assign key_valid_o = valid_q;
endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk #(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int BOUNCE_CYC = 100000,
  parameter int KW         = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [COLS-1:0] col_o,
  input logic            detect_o,
  input logic [KW-1:0]   key_idx_o,
  input logic            key_valid_o
);
  localparam int ZW = $clog2(BOUNCE_CYC + 2);

  logic [COLS-1:0] col_q;
  logic [ZW-1:0]   zrun;
  int              key_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      zrun  <= '0;
    end else begin
      col_q <= col_o;
      if (col_o != '0)                   zrun <= '0;
      else if (zrun != ZW'(BOUNCE_CYC)) zrun <= zrun + 1'b1;
    end
  end

  assign key_col = int'(key_idx_o) % COLS;

  a_r5_col_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o == '0) || ($countones(col_o) == COLS - 1));

  a_r3_detect_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |=> !detect_o);

  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);

  a_r6_key_column: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> (col_q[key_col] == 1'b0) && ($countones(col_q) == COLS - 1));

  a_r9_hold_cols_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> (col_o == '0));

  a_r4_bounce_before_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((col_q == '0) && (col_o != '0)) |-> (zrun == ZW'(BOUNCE_CYC)));

  a_r1_detect_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> (col_o == '0));
endmodule

bind keypad_scanner keypad_scanner_chk #(
  .ROWS(ROWS), .COLS(COLS), .BOUNCE_CYC(BOUNCE_CYC), .KW(KW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .col_o       (col_o),
  .detect_o    (detect_o),
  .key_idx_o   (key_idx_o),
  .key_valid_o (key_valid_o)
);

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
  localparam int BOUNCE = 40;
  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row;
  logic [3:0] col;
  logic       preq, det, kval;
  logic [3:0] kidx;
  logic [15:0] keys = '0;

  int n_run = 0, n_fail = 0;
  int vcnt = 0, dcnt = 0, last_idx = -1;
  int seq[8];
  int seq_n = 0, min_hold = 1000, hold = 0, gap = -1, zcnt = 0;
  bit gap_open = 0, finished = 0;
  logic [3:0] prev_col = 4'b0000;

  always #5 clk = ~clk;

  keypad_scanner #(.BOUNCE_CYC(BOUNCE), .SETTLE_CYC(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .row_i(row), .col_o(col),
    .press_req_o(preq), .detect_o(det), .key_idx_o(kidx), .key_valid_o(kval)
  );

  // switch matrix model: row r low when a closed key at (r,c) meets a low column c
  always_comb begin
    row = 4'b1111;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (keys[r*4+c] && !col[c]) row[r] = 1'b0;
  end

  function automatic int low_idx(logic [3:0] c);
    int n = 0, k = -1;
    for (int i = 0; i < 4; i++) if (!c[i]) begin n++; k = i; end
    return (n == 1) ? k : -1;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (kval) begin vcnt++; last_idx = int'(kidx); end
    if (det) begin
      dcnt++; seq_n = 0; min_hold = 1000; gap_open = 1; zcnt = 0; gap = -1;
    end
    if (gap_open) begin
      if (col == 4'b0000) zcnt++;
      else begin gap = zcnt; gap_open = 0; end
    end
    if (col != prev_col) begin
      if (low_idx(prev_col) >= 0 && hold < min_hold) min_hold = hold;
      if (low_idx(col) >= 0) begin
        if (seq_n < 8) seq[seq_n] = low_idx(col);
        seq_n++; hold = 1;
      end
    end else if (low_idx(col) >= 0) hold++;
    prev_col = col;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bounce_to(logic [15:0] m);
    for (int k = 0; k < 3; k++) begin
      keys = m; tick(3); keys = '0; tick(2);
    end
    keys = m;
  endtask

  task automatic release_bounce(logic [15:0] m);
    for (int k = 0; k < 3; k++) begin
      keys = '0; tick(2); keys = m; tick(2);
    end
    keys = '0;
  endtask

  task automatic wait_valid(int v0);
    for (int i = 0; i < 600 && vcnt == v0; i++) tick(1);
  endtask

  task automatic t_reset;
    check(col == 4'b0000, "R1", "col after reset", int'(col), 0);
    check(kval == 1'b0, "R1", "valid after reset", int'(kval), 0);
    check(det == 1'b0, "R1", "detect after reset", int'(det), 0);
    check(preq == 1'b1, "R2", "request with no key", int'(preq), 1);
  endtask

  task automatic t_press(int r, int c);
    int v0 = vcnt, d0 = dcnt;
    logic [15:0] m = 16'(1) << (r*4 + c);
    bounce_to(m);
    tick(1);
    check(preq == 1'b0, "R2", "request with key held", int'(preq), 0);
    wait_valid(v0);
    check(last_idx == r*4 + c, "R6", "key index", last_idx, r*4 + c);
    check(gap >= BOUNCE, "R4", "low cols after detect", gap, BOUNCE);
    check(min_hold >= SETTLE, "R5", "column hold", min_hold, SETTLE);
    tick(60);
    check(col == 4'b0000, "R9", "cols while held", int'(col), 0);
    release_bounce(m);
    tick(3*BOUNCE);
    check(vcnt - v0 == 1, "R7", "valid pulses per press", vcnt - v0, 1);
    check(dcnt - d0 == 1, "R3", "detects per press", dcnt - d0, 1);
  endtask

  task automatic t_glitch;
    int v0 = vcnt, d0 = dcnt;
    keys = 16'h0001; tick(3); keys = '0;
    tick(3*BOUNCE + 60);
    check(dcnt - d0 == 1, "R8", "glitch detect", dcnt - d0, 1);
    check(vcnt == v0, "R8", "glitch report", vcnt - v0, 0);
    check(seq_n == 4, "R5", "columns scanned", seq_n, 4);
    for (int i = 0; i < 4; i++)
      check(seq[i] == i, "R5", "scan order", seq[i], i);
    check(col == 4'b0000, "R8", "cols back to idle", int'(col), 0);
  endtask

  task automatic t_rearm;
    int v0 = vcnt, d0 = dcnt;
    keys = 16'(1) << 5;
    wait_valid(v0);
    keys = '0; tick(10);
    keys = 16'(1) << 10; tick(20);   // inside quiet interval: swallowed
    keys = '0; tick(BOUNCE - 10);
    check(dcnt - d0 == 1, "R9", "detect before rearm", dcnt - d0, 1);
    keys = 16'(1) << 10; tick(4); keys = '0;  // still inside restarted interval
    tick(3*BOUNCE);
    check(vcnt - v0 == 1, "R9", "valid before rearm", vcnt - v0, 1);
    check(dcnt - d0 == 1, "R9", "no early detect", dcnt - d0, 1);
    t_press(2, 2);
  endtask

  task automatic t_multi(logic [15:0] m, int exp);
    int v0 = vcnt;
    keys = m;
    wait_valid(v0);
    check(last_idx == exp, "R10", "multi-key priority", last_idx, exp);
    keys = '0; tick(3*BOUNCE);
    check(vcnt - v0 == 1, "R10", "multi-key single report", vcnt - v0, 1);
  endtask

  task automatic finish_tb;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset;
    t_press(0, 0);
    t_press(1, 2);
    t_press(3, 3);
    t_press(2, 1);
    t_glitch;
    t_rearm;
    t_multi(16'(1) << 2 | 16'(1) << 14, 2);   // rows 0,3 in column 2
    t_multi(16'(1) << 7 | 16'(1) << 9, 9);    // (1,3) and (2,1): column 1 first
    finish_tb;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_tb;
    end
  end
endmodule